// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch will be taken. It holds a short shift register of recent branch outcomes and several banks of two-bit prediction entries. The current history value picks one bank, and a few low bits of the fetch address pick an entry inside it. The upper bit of that entry is the prediction, and it is returned in the same cycle as the address.

When the execute stage resolves a branch, it sends back the branch address, the real outcome and the history value that was handed out with the prediction. That history value selects the bank to train. The addressed entry then moves through a four-state machine that keeps both a direction and a flag saying whether the last guess was wrong. The direction only flips after two wrong guesses in a row. The resolved outcome also shifts into the history register.

The block produces only the direction bit. Target addresses, history repair after a flush and the choice of the next fetch address belong to the surrounding fetch logic.

Top module: `gh_branch_predictor`

## Requirements
- R1: `lk_taken` is bit 1 of the entry chosen by the current history (bank number) and by `lk_pc[IDX_W+1:2]` (entry number). It is valid in the same cycle as `lk_pc`, with no register in the path.
- R2: Each entry has two bits. Bit 1 is the predicted direction (1 = taken). Bit 0 is set when the last prediction from that entry was wrong. When an update's outcome matches the direction of an entry marked right, the entry does not change.
- R3: When the outcome differs from the direction of an entry marked right, the entry keeps its direction and becomes marked wrong. One miss never flips a prediction.
- R4: When the outcome differs from the direction of an entry marked wrong, the direction flips and the entry stays marked wrong.
- R5: When the outcome matches the direction of an entry marked wrong, the entry keeps its direction and becomes marked right.
- R6: On each cycle with `upd_valid` high, the history becomes {previous bit 0, `upd_taken`}, so bit 0 is the newest outcome. Without `upd_valid`, the history holds its value. `lk_hist` shows the current history.
- R7: After a synchronous active-low reset, the history is 00 and every entry holds 00 (not taken, marked right).
- R8: An update trains the bank selected by `upd_hist`, not the bank selected by the current history. No other entry changes.
- R9: When a lookup and an update address the same entry in the same cycle, `lk_taken` shows the value the entry held before the update.
- R10: Address bits [1:0] and every bit above `IDX_W+1` have no effect on which entry a lookup or an update uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | PC_W | Fetch address being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | HIST_W | History value used for this lookup; travels with the branch |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History value that was returned when this branch was predicted |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
A lookup and an update can fall in the same cycle, and they can address the same entry. The bench provokes this by driving a lookup and an update of one address together, choosing an outcome that flips that entry. It expects the old direction in that cycle. It then steers the history back to the same bank and expects the new direction on a later lookup. Every other lookup is compared against a reference model in the bench that is trained only after the expected value has been queued.

// File: rtl/bp_pkg.sv
// Shared types for the branch direction predictor.
// Entry encoding: bit 1 = predicted direction (1 = taken), bit 0 = last guess was wrong.
package bp_pkg;

    typedef enum logic [1:0] {
        ST_NT_RIGHT = 2'b00,
        ST_NT_WRONG = 2'b01,
        ST_T_RIGHT  = 2'b10,
        ST_T_WRONG  = 2'b11
    } ctr_t;

endpackage

// File: rtl/bp_history.sv
// Global outcome history shift register.
// Assumes one resolved branch at most per cycle; the newest outcome lands in bit 0.
module bp_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              taken,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_q;

    generate
        if (HIST_W == 1) begin : g_single
            // Keep only the latest outcome.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist_q <= '0;
                else if (shift_en) hist_q <= taken;
            end
        end else begin : g_shift
            // Shift the latest outcome in at bit 0 and drop the oldest bit.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist_q <= '0;
                else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], taken};
            end
        end
    endgenerate

    assign hist = hist_q;

endmodule

// File: rtl/bp_entry_next.sv
// Next-state function of one two-bit prediction entry.
// The direction changes only when an entry already marked wrong misses again.
module bp_entry_next
    import bp_pkg::*;
(
    input  ctr_t cur,
    input  logic taken,
    output ctr_t nxt
);

    logic dir;
    logic was_wrong;
    logic miss;

    assign dir       = cur[1];
    assign was_wrong = cur[0];
    assign miss      = (dir != taken);

    // Choose the new state from the hit/miss result and the current right/wrong flag.
    always_comb begin
        if (!miss)          nxt = ctr_t'({dir, 1'b0});
        else if (!was_wrong) nxt = ctr_t'({dir, 1'b1});
        else                 nxt = ctr_t'({~dir, 1'b1});
    end

endmodule

// File: rtl/bp_bank.sv
// One bank of 2**IDX_W prediction entries.
// It has one combinational read port and one write port that applies the entry
// next-state function. A read of the entry being written returns the old value.
module bp_bank
    import bp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t ent [DEPTH];
    ctr_t wr_cur;
    ctr_t wr_nxt;

    assign wr_cur = ent[wr_idx];

    bp_entry_next u_next (
        .cur   (wr_cur),
        .taken (wr_taken),
        .nxt   (wr_nxt)
    );

    // Clear every entry on reset; otherwise write the trained state of the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= ST_NT_RIGHT;
        end else if (wr_en) begin
            ent[wr_idx] <= wr_nxt;
        end
    end

    assign rd_state = ent[rd_idx];

endmodule

// File: rtl/gh_branch_predictor.sv
// Two-level branch direction predictor with a global history.
// The current history selects one of 2**HIST_W banks for lookup. An update trains
// the bank named by the history value returned at prediction time.
// Assumes word-aligned addresses, so the entry index starts at bit 2.
module gh_branch_predictor
    import bp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 4,
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_taken
);

    localparam int BANKS = 1 << HIST_W;
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  upd_idx;
    logic [HIST_W-1:0] ghr;
    ctr_t              bank_rd [BANKS];

    // Address bits that do not take part in indexing.
    logic lk_pc_unused;
    logic upd_pc_unused;
    assign lk_pc_unused  = ^{lk_pc[PC_W-1:IDX_HI+1], lk_pc[IDX_LO-1:0]};
    assign upd_pc_unused = ^{upd_pc[PC_W-1:IDX_HI+1], upd_pc[IDX_LO-1:0]};

    assign lk_idx  = lk_pc[IDX_HI:IDX_LO];
    assign upd_idx = upd_pc[IDX_HI:IDX_LO];

    bp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .taken    (upd_taken),
        .hist     (ghr)
    );

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic wr_sel;
            assign wr_sel = upd_valid && (upd_hist == HIST_W'(b));

            bp_bank #(.IDX_W(IDX_W)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .rd_idx   (lk_idx),
                .rd_state (bank_rd[b]),
                .wr_en    (wr_sel),
                .wr_idx   (upd_idx),
                .wr_taken (upd_taken)
            );
        end
    endgenerate

    assign lk_taken = bank_rd[ghr][1];
    assign lk_hist  = ghr;

endmodule

// File: rtl/gh_bp_checker.sv
// Port-level properties of the branch direction predictor.
module gh_bp_checker #(
    parameter int HIST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_taken,
    input logic [HIST_W-1:0] lk_hist,
    input logic              upd_valid,
    input logic              upd_taken
);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (lk_hist == '0) && !lk_taken); // R7

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (lk_hist[0] == $past(upd_taken)) && (lk_hist[1] == $past(lk_hist[0]))); // R6

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(lk_hist)); // R6

    AST_NO_TRAIN_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid && !$past(!rst_n) |=> $stable(lk_hist) && $past(lk_hist) == lk_hist); // R8

endmodule

bind gh_branch_predictor gh_bp_checker #(.HIST_W(HIST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_taken  (lk_taken),
    .lk_hist   (lk_hist),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken)
);

// File: tb/gh_branch_predictor_test.sv
// Scoreboard bench: the driver queues the expected lookup result from a reference model
// before it trains that model; a monitor pops each item at the falling edge and compares it.
module gh_branch_predictor_test;

    localparam int PC_W = 32;
    localparam int IDX_W = 4;
    localparam int HIST_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   lk_pc = '0;
    logic              lk_taken;
    logic [HIST_W-1:0] lk_hist;
    logic              upd_valid = 1'b0;
    logic [PC_W-1:0]   upd_pc = '0;
    logic [HIST_W-1:0] upd_hist = '0;
    logic              upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic       taken;
        logic [1:0] hist;
        string      tag;
    } exp_t;

    exp_t q[$];

    bit [1:0] m_ent [4][16];
    bit [1:0] m_hist;

    localparam logic [31:0] PA = 32'h0000_0040;
    localparam logic [31:0] PB = 32'h0000_0044;
    localparam logic [31:0] PZ = 32'h0000_003C;

    always #2.5 clk = ~clk;

    gh_branch_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (lk_pc),
        .lk_taken  (lk_taken),
        .lk_hist   (lk_hist),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_hist  (upd_hist),
        .upd_taken (upd_taken)
    );

    function automatic bit [3:0] idx_of(input logic [31:0] pc);
        return pc[5:2];
    endfunction

    // Reference training per R2..R5: a hit clears the wrong mark, the first miss sets it,
    // and a second miss flips the direction.
    function automatic bit [1:0] train(input bit [1:0] s, input bit t);
        if (s[1] == t) return {s[1], 1'b0};
        if (!s[0])     return {s[1], 1'b1};
        return {~s[1], 1'b1};
    endfunction

    // One clock of stimulus: optional lookup (queued expectation) and optional update.
    task automatic step(input bit dl, input logic [31:0] lpc, input bit du,
                        input logic [31:0] upc, input bit [1:0] uh, input bit ut,
                        input string tag);
        @(posedge clk);
        #1;
        lk_pc     = lpc;
        upd_valid = du;
        upd_pc    = upc;
        upd_hist  = uh;
        upd_taken = ut;
        if (dl) q.push_back('{m_ent[m_hist][idx_of(lpc)][1], m_hist, tag});
        if (du) begin
            m_ent[uh][idx_of(upc)] = train(m_ent[uh][idx_of(upc)], ut);
            m_hist = {m_hist[0], ut};
        end
    endtask

    task automatic up(input logic [31:0] pc, input bit t, input string tag);
        step(1, pc, 1, pc, m_hist, t, tag);
    endtask

    task automatic look(input logic [31:0] pc, input string tag);
        step(1, pc, 0, '0, 2'b00, 0, tag);
    endtask

    task automatic hist_zero();
        up(PZ, 0, "R6");
        up(PZ, 0, "R6");
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Monitor: compare one queued expectation per cycle, away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (lk_taken !== e.taken || lk_hist !== e.hist) begin
                    errors++;
                    $display("FAIL %s taken=%0b hist=%0b expected taken=%0b hist=%0b",
                             e.tag, lk_taken, lk_hist, e.taken, e.hist);
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 16; i++) m_ent[b][i] = 2'b00;
        m_hist = 2'b00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R7: reset state seen through lookups
        look(PA, "R7");
        look(32'h0000_007C, "R7");

        // R3: one miss does not flip
        up(PA, 1, "R3");
        hist_zero();
        look(PA, "R3");

        // R4: second miss flips
        up(PA, 1, "R4");
        hist_zero();
        look(PA, "R4");

        // R5: a hit on a wrong-marked entry re-marks it right, so one later miss keeps it
        up(PA, 1, "R5");
        hist_zero();
        up(PA, 0, "R5");
        hist_zero();
        look(PA, "R5");
        up(PA, 0, "R4");
        hist_zero();
        look(PA, "R4");

        // R8: training goes to the bank named on the update port
        step(0, '0, 1, PB, 2'b10, 1, "R8");
        step(0, '0, 1, PB, 2'b10, 1, "R8");
        hist_zero();
        look(PB, "R8");
        up(PZ, 1, "R8");
        up(PZ, 0, "R8");
        look(PB, "R8");

        // R10: offset bits and high bits do not change the entry
        look(32'hABCD_0447, "R10");

        // R9: same-cycle lookup and update of one entry returns the old value
        up(PB, 0, "R9");
        up(PZ, 1, "R9");
        up(PZ, 0, "R9");
        look(PB, "R9");

        // R6: history holds across idle cycles
        look(PA, "R6");
        look(PA, "R6");
        look(PB, "R6");

        // R1, R2: mixed traffic across many entries and banks
        for (int i = 0; i < 200; i++) begin
            logic [31:0] lp;
            logic [31:0] upc;
            bit t;
            lp  = 32'(i * 52) ^ 32'(i << 7);
            upc = 32'((i % 5) * 4 + 32'h100);
            t   = ((i * 7) % 3) != 0;
            step(1, lp, (i % 4) != 3, upc, m_hist, t, (i % 2) ? "R1" : "R2");
        end

        step(0, '0, 0, '0, 2'b00, 0, "R1");
        @(posedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule